// File: doc/BRIEF.md
# Binary Early/Late Phase Detector

This block decides, once per recovered-clock period, whether the sampling clock of a clock-recovery loop sits early or late relative to the incoming serial data. Three samples are taken around each possible bit boundary. The previous bit-centre data sample is held inside the block. The current bit-centre sample and the edge sample taken between the two centres arrive as inputs on a fast clock, qualified by a valid strobe. When the two data samples differ, a boundary has occurred. The edge sample then shows on which side of the boundary the clock fell, and the block emits a one-cycle speed-up or slow-down pulse. The pulse carries no magnitude.

When no boundary occurs, neither pulse is produced, so long runs of identical bits leave the loop unchanged. A saturating signed integrator sums the pulses (+1 for speed-up, −1 for slow-down), so the block can be checked on its own without an external loop filter. A parameter removes the integrator. Reset is synchronous and active high.

Top module: `bbpd`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `up`, `dn`, `integ` and the stored previous data sample to zero.
- R2: A valid sample whose `smp_data` equals the stored previous data sample produces neither `up` nor `dn` in the following cycle.
- R3: A valid sample with `smp_data` different from the stored sample and `smp_edge` equal to `smp_data` means the clock is late. `up` is high for exactly the next cycle.
- R4: A valid sample with `smp_data` different from the stored sample and `smp_edge` equal to the stored sample means the clock is early. `dn` is high for exactly the next cycle.
- R5: `up` and `dn` are never high in the same cycle.
- R6: A cycle with `smp_vld` low produces no pulse. It leaves the stored data sample and `integ` unchanged.
- R7: In the cycle in which `up` (or `dn`) is high, `integ` is one above (below) its previous value, unless that value was at its limit.
- R8: `integ` is a two's-complement value of `ACC_W` bits. It clamps at 2^(ACC_W−1)−1 on speed-up and at −2^(ACC_W−1) on slow-down.
- R9: Each valid sample stores its `smp_data` as the previous data sample. After reset the stored sample is 0, so a first valid sample with `smp_data`=1 counts as a boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Current samples are valid this cycle |
| smp_edge | input | 1 | Edge sample between previous and current bit centre |
| smp_data | input | 1 | Data sample at current bit centre |
| up | output | 1 | Clock late: speed up (one-cycle pulse) |
| dn | output | 1 | Clock early: slow down (one-cycle pulse) |
| integ | output | ACC_W | Saturating signed sum of decisions |

## Verification
The assertions check on every cycle that the two pulses never coincide and that each late, early or boundary-free sample maps to the right pulse one cycle later. They also check that the stored sample follows valid data, that `integ` steps by one or holds at a limit, and that it stays still when nothing is valid. Only the bench scenarios can show that these per-cycle rules add up to the right totals. Those scenarios cover long one-sided runs that reach saturation, the first decision against the cleared stored sample after reset, and the recovery from a clamped value back toward zero.

// File: rtl/bbpd.sv
module bbpd #(
  parameter int ACC_W  = 8,
  parameter bit ACC_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_vld,
  input  logic                    smp_edge,
  input  logic                    smp_data,
  output logic                    up,
  output logic                    dn,
  output logic signed [ACC_W-1:0] integ
);

  localparam logic signed [ACC_W-1:0] I_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] I_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] I_ONE = {{(ACC_W-1){1'b0}}, 1'b1};

  logic prev_q;
  logic trans, late_c, early_c;

  assign trans   = smp_vld && (prev_q != smp_data);
  assign late_c  = trans && (smp_edge == smp_data);
  assign early_c = trans && (smp_edge == prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      up     <= 1'b0;
      dn     <= 1'b0;
    end else begin
      up <= late_c;
      dn <= early_c;
      if (smp_vld) prev_q <= smp_data;
    end
  end

  generate
    if (ACC_EN) begin : g_acc
      always_ff @(posedge clk) begin
        if (rst)                           integ <= '0;
        else if (late_c  && integ != I_MAX) integ <= integ + I_ONE;
        else if (early_c && integ != I_MIN) integ <= integ - I_ONE;
      end
    end else begin : g_noacc
      assign integ = '0;
    end
  endgenerate

endmodule

// File: rtl/bbpd_chk.sv
module bbpd_chk #(
  parameter int ACC_W  = 8,
  parameter bit ACC_EN = 1'b1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    smp_vld,
  input logic                    smp_edge,
  input logic                    smp_data,
  input logic                    prev_q,
  input logic                    up,
  input logic                    dn,
  input logic signed [ACC_W-1:0] integ
);
  localparam logic signed [ACC_W-1:0] C_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] C_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] C_ONE = {{(ACC_W-1){1'b0}}, 1'b1};

  p_mutex_r5: assert property (@(posedge clk) disable iff (rst) !(up && dn));

  p_late_r3: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && smp_data != prev_q && smp_edge == smp_data) |=> (up && !dn));

  p_early_r4: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && smp_data != prev_q && smp_edge == prev_q) |=> (dn && !up));

  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && smp_data == prev_q) |=> (!up && !dn));

  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> (!up && !dn && $stable(integ) && $stable(prev_q)));

  p_store_r9: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> (prev_q == $past(smp_data)));

  p_step_up_r7: assert property (@(posedge clk) disable iff (rst)
    (ACC_EN && smp_vld && smp_data != prev_q && smp_edge == smp_data && integ != C_MAX)
      |=> (integ == $past(integ) + C_ONE));

  p_step_dn_r7: assert property (@(posedge clk) disable iff (rst)
    (ACC_EN && smp_vld && smp_data != prev_q && smp_edge == prev_q && integ != C_MIN)
      |=> (integ == $past(integ) - C_ONE));

  p_clamp_hi_r8: assert property (@(posedge clk) disable iff (rst)
    (integ == C_MAX && !dn) |=> (integ == C_MAX || dn));

  p_clamp_lo_r8: assert property (@(posedge clk) disable iff (rst)
    (integ == C_MIN && !up) |=> (integ == C_MIN || up));

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!up && !dn && prev_q == 1'b0 && (!ACC_EN || integ == '0)));
endmodule

bind bbpd bbpd_chk #(.ACC_W(ACC_W), .ACC_EN(ACC_EN)) u_chk (
  .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_edge(smp_edge),
  .smp_data(smp_data), .prev_q(prev_q), .up(up), .dn(dn), .integ(integ)
);

// File: tb/bbpd_tb.sv
module bbpd_tb;
  localparam int W  = 4;
  localparam int MX = 7;
  localparam int MN = -8;

  logic clk = 1'b0;
  logic rst, smp_vld, smp_edge, smp_data;
  logic up, dn;
  logic signed [W-1:0] integ;

  int vecs = 0;
  int errs = 0;
  int m_prev = 0;
  int m_acc  = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bbpd #(.ACC_W(W), .ACC_EN(1'b1)) u_dut (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_edge(smp_edge),
    .smp_data(smp_data), .up(up), .dn(dn), .integ(integ)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit e, input bit d, input string note);
    int eu, ed;
    string t;
    smp_vld = v; smp_edge = e; smp_data = d;
    eu = (v && d != m_prev && e == d) ? 1 : 0;
    ed = (v && d != m_prev && e == m_prev) ? 1 : 0;
    if (!v)              t = "R6";
    else if (d == m_prev) t = "R2";
    else if (eu == 1)    t = "R3";
    else                 t = "R4";
    if (eu == 1 && m_acc < MX) m_acc++;
    if (ed == 1 && m_acc > MN) m_acc--;
    if (v) m_prev = d;
    @(negedge clk);
    chk({t, " up ", note}, int'(up), eu);
    chk({t, " dn ", note}, int'(dn), ed);
    chk((m_acc == MX || m_acc == MN) ? "R8 integ" : "R7 integ", int'(integ), m_acc);
    if (up && dn) chk("R5 both pulses", 1, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1; smp_vld = 1'b0; smp_edge = 1'b1; smp_data = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_prev = 0; m_acc = 0;
    chk("R1 up", int'(up), 0);
    chk("R1 dn", int'(dn), 0);
    chk("R1 integ", int'(integ), 0);
  endtask

  initial begin
    smp_vld = 1'b0; smp_edge = 1'b0; smp_data = 1'b0;
    @(negedge clk);
    do_reset();

    // R9: stored sample is 0 after reset, so data=1 is a boundary
    step(1'b1, 1'b1, 1'b1, "R9 first late after reset");
    do_reset();
    step(1'b1, 1'b0, 1'b1, "R9 first early after reset");

    // exhaustive three-step paths over (vld, edge, data)
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 8; c++) begin
          step(a[2], a[1], a[0], "sweep");
          step(b[2], b[1], b[0], "sweep");
          step(c[2], c[1], c[0], "sweep");
        end

    // R8: saturate high with repeated late patterns, then low with early
    do_reset();
    for (int k = 0; k < 12; k++) step(1'b1, ~m_prev[0], ~m_prev[0], "R8 late run");
    chk("R8 clamp high", int'(integ), MX);
    step(1'b0, 1'b1, 1'b1, "R6 idle keeps max");
    for (int k = 0; k < 20; k++) step(1'b1, m_prev[0], ~m_prev[0], "R8 early run");
    chk("R8 clamp low", int'(integ), MN);
    for (int k = 0; k < 3; k++) step(1'b1, ~m_prev[0], ~m_prev[0], "R7 recover");
    chk("R7 recovery value", int'(integ), MN + 3);

    // R2: long run without transitions leaves everything unchanged
    for (int k = 0; k < 10; k++) step(1'b1, 1'b0, m_prev[0], "R2 no transition run");

    // pseudo-random mix
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int k = 0; k < 3000; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[0] | lfsr[5], lfsr[1], lfsr[2], "mix");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule